// File: doc/BRIEF.md
# External Bus Cycle Timing Sequencer

This block times one access on an external memory bus after the address decode has already picked a chip-select window. It takes that window's timing fields as inputs: setup delay, primary and secondary wait counts, auto-acknowledge, read and write hold codes, and extended start. It also takes a start pulse, a direction flag, a beat count, a base address and the external transfer-acknowledge pin. From these it produces a transfer-start strobe, a chip-select enable, an address-valid window, the beat address, an internal acknowledge for each beat and a one-clock done pulse.

An access passes through four phases: address setup, chip-select with one or more beats, address hold, then idle. The timing fields, the direction and the beat count are captured when the start is accepted. Changes on those inputs during an access therefore have no effect, and a start that arrives during an access is ignored. In this document, "cycle k" is the k-th clock period after the edge that accepts the start, counting from 0.

Top module: `ebus_cycle_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start, ts_out, cs_en, addr_valid, int_ack and done are all 0. Reset clears an access that is in progress.
- R2: addr_valid rises in cycle 0. cs_en rises in cycle S+1, where S is the 2-bit setup_code (0 to 3).
- R3: With auto_ack_en=1 and no external acknowledge, int_ack is high in exactly the W-th cycle of a beat counted from 0, where W is the 6-bit wait count (0 to 63). The beat ends in that cycle.
- R4: An ext_ack that is high in cycle r of a beat ends the beat in that cycle. With auto_ack_en=1 this happens even when r is less than W, and int_ack then stays low for that beat. With auto_ack_en=0, int_ack never asserts and only ext_ack ends a beat.
- R5: The first beat uses wait_pri. Later beats use wait_sec when sec_wait_en=1 and wait_pri otherwise.
- R6: For a write (is_write=1), addr_valid stays high for wr_hold+1 cycles after cs_en falls.
- R7: For a read, addr_valid stays high for rd_hold+1 cycles after cs_en falls when auto_ack_en=0, and for rd_hold cycles when auto_ack_en=1 (0 cycles for code 0).
- R8: cs_en stays high without a gap across all beats_m1+1 beats. Hold time is added only after the last beat.
- R9: With ext_start_en=0, ts_out is high only in cycle 0. With ext_start_en=1, it stays high through cycle S+1, the first cycle with cs_en high.
- R10: done is high for exactly one cycle: the first cycle after the hold ends, or the cycle after the last beat when the hold is 0. In that cycle addr_valid is 0.
- R11: A start that arrives while addr_valid is high is ignored. Timing, direction, beat-count and base inputs that change after acceptance do not alter the access in progress.
- R12: addr_out equals base_addr + b*ADDR_STEP during beat b (counted from 0). It advances on each beat termination except the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request one access; accepted only when idle |
| is_write | input | 1 | 1 = write, 0 = read |
| beats_m1 | input | EB_BEAT_W | Number of beats minus one |
| base_addr | input | ADDR_W | Address of the first beat |
| setup_code | input | EB_CODE_W | Setup delay code S |
| wait_pri | input | EB_WAIT_W | Wait states for the first beat |
| wait_sec | input | EB_WAIT_W | Wait states for later beats when enabled |
| sec_wait_en | input | 1 | Use wait_sec after the first beat |
| auto_ack_en | input | 1 | Generate the internal acknowledge after the wait count |
| wr_hold | input | EB_CODE_W | Write hold code |
| rd_hold | input | EB_CODE_W | Read hold code |
| ext_start_en | input | 1 | Stretch the start strobe into the first chip-select cycle |
| ext_ack | input | 1 | External transfer acknowledge |
| ts_out | output | 1 | Transfer-start strobe |
| cs_en | output | 1 | Chip-select enable |
| addr_valid | output | 1 | Address and attributes driven (setup, beats, hold) |
| addr_out | output | ADDR_W | Current beat address |
| int_ack | output | 1 | Internal acknowledge for the current beat |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
Every output is a decode of registers, so each result is due in a cycle that can be computed in advance. addr_valid and ts_out rise in cycle 0. cs_en rises in cycle S+1. A beat of length L+1 hands over to the next beat one cycle after its terminating acknowledge. addr_valid falls H cycles after cs_en falls, and done lands in that same cycle. The bench derives these cycle numbers from the configuration alone. It drives and samples on the falling edge, reading cycle k at the falling edge inside it, and it sets ext_ack in the same half-period so that the rising edge which closes cycle k sees it. It compares every output in every cycle from acceptance through one idle cycle after done, so an early or late edge anywhere is caught.

// File: rtl/ebus_seq_pkg.sv
package ebus_seq_pkg;

  parameter int EB_CODE_W = 2;
  parameter int EB_WAIT_W = 6;
  parameter int EB_BEAT_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_WAIT  = 2'd2,
    ST_HOLD  = 2'd3
  } seq_state_e;

  // Per-access settings frozen at acceptance.
  typedef struct packed {
    logic                 is_write;
    logic [EB_BEAT_W-1:0] beats_m1;
    logic [EB_WAIT_W-1:0] wait_pri;
    logic [EB_WAIT_W-1:0] wait_sec;
    logic                 sec_en;
    logic                 auto_ack;
    logic [EB_CODE_W-1:0] wr_hold;
    logic [EB_CODE_W-1:0] rd_hold;
    logic                 ext_start;
  } eb_cfg_t;

endpackage

// File: rtl/ebus_rst_sync.sv
module ebus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/ebus_dcount.sv
// Loadable down-counter that saturates at zero.
module ebus_dcount #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                  cnt_d = load_val;
    else if (dec && cnt_q != '0) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ebus_cfg_latch.sv
module ebus_cfg_latch
  import ebus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cap_en,
  input  eb_cfg_t cfg_in,
  output eb_cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cap_en) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/ebus_addr_gen.sv
module ebus_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int ADDR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load)     addr_d = base;
    else if (adv) addr_d = addr_q + ADDR_W'(ADDR_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/ebus_seq_fsm.sv
module ebus_seq_fsm
  import ebus_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  eb_cfg_t              cfg,
  input  logic                 ext_ack,
  input  logic                 setup_zero,
  input  logic                 wait_zero,
  input  logic                 hold_zero,
  output logic                 accept,
  output logic                 setup_dec,
  output logic                 wait_ld,
  output logic [EB_WAIT_W-1:0] wait_val,
  output logic                 wait_dec,
  output logic                 hold_ld,
  output logic [EB_CODE_W-1:0] hold_val,
  output logic                 hold_dec,
  output logic                 addr_adv,
  output logic                 ts_out,
  output logic                 cs_en,
  output logic                 addr_valid,
  output logic                 int_ack,
  output logic                 done
);
  seq_state_e           st_q, st_d;
  logic                 ts_q, ts_d;
  logic                 done_q, done_d;
  logic [EB_BEAT_W-1:0] beat_q, beat_d;

  logic beat_end, last_beat, no_hold;

  assign int_ack   = (st_q == ST_WAIT) && cfg.auto_ack && wait_zero;
  assign beat_end  = ext_ack || int_ack;
  assign last_beat = (beat_q == cfg.beats_m1);
  // A read with auto-acknowledge and code 0 has no hold at all.
  assign no_hold   = !cfg.is_write && cfg.auto_ack && (cfg.rd_hold == '0);

  always_comb begin
    if (cfg.is_write)      hold_val = cfg.wr_hold;
    else if (cfg.auto_ack) hold_val = cfg.rd_hold - EB_CODE_W'(1);
    else                   hold_val = cfg.rd_hold;
  end

  always_comb begin
    st_d      = st_q;
    ts_d      = 1'b0;
    done_d    = 1'b0;
    beat_d    = beat_q;
    accept    = 1'b0;
    setup_dec = 1'b0;
    wait_ld   = 1'b0;
    wait_val  = cfg.wait_pri;
    wait_dec  = 1'b0;
    hold_ld   = 1'b0;
    hold_dec  = 1'b0;
    addr_adv  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          accept = 1'b1;
          st_d   = ST_SETUP;
          ts_d   = 1'b1;
          beat_d = '0;
        end
      end
      ST_SETUP: begin
        ts_d = ts_q && cfg.ext_start;
        if (setup_zero) begin
          st_d    = ST_WAIT;
          wait_ld = 1'b1;
        end else begin
          setup_dec = 1'b1;
        end
      end
      ST_WAIT: begin
        if (beat_end) begin
          if (last_beat) begin
            if (no_hold) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end else begin
              st_d    = ST_HOLD;
              hold_ld = 1'b1;
            end
          end else begin
            wait_ld  = 1'b1;
            wait_val = cfg.sec_en ? cfg.wait_sec : cfg.wait_pri;
            beat_d   = beat_q + EB_BEAT_W'(1);
            addr_adv = 1'b1;
          end
        end else begin
          wait_dec = 1'b1;
        end
      end
      ST_HOLD: begin
        if (hold_zero) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          hold_dec = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ts_q   <= 1'b0;
      done_q <= 1'b0;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      ts_q   <= ts_d;
      done_q <= done_d;
      beat_q <= beat_d;
    end
  end

  assign ts_out     = ts_q;
  assign done       = done_q;
  assign cs_en      = (st_q == ST_WAIT);
  assign addr_valid = (st_q != ST_IDLE);
endmodule

// File: rtl/ebus_cycle_seq.sv
module ebus_cycle_seq
  import ebus_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ADDR_STEP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 is_write,
  input  logic [EB_BEAT_W-1:0] beats_m1,
  input  logic [ADDR_W-1:0]    base_addr,
  input  logic [EB_CODE_W-1:0] setup_code,
  input  logic [EB_WAIT_W-1:0] wait_pri,
  input  logic [EB_WAIT_W-1:0] wait_sec,
  input  logic                 sec_wait_en,
  input  logic                 auto_ack_en,
  input  logic [EB_CODE_W-1:0] wr_hold,
  input  logic [EB_CODE_W-1:0] rd_hold,
  input  logic                 ext_start_en,
  input  logic                 ext_ack,
  output logic                 ts_out,
  output logic                 cs_en,
  output logic                 addr_valid,
  output logic [ADDR_W-1:0]    addr_out,
  output logic                 int_ack,
  output logic                 done
);
  logic    rst_int_n;
  eb_cfg_t cfg_in, cfg_q;
  logic    accept, setup_dec, wait_ld, wait_dec, hold_ld, hold_dec, addr_adv;
  logic    setup_zero, wait_zero, hold_zero;
  logic [EB_WAIT_W-1:0] wait_val;
  logic [EB_CODE_W-1:0] hold_val;

  assign cfg_in = '{is_write:  is_write,
                    beats_m1:  beats_m1,
                    wait_pri:  wait_pri,
                    wait_sec:  wait_sec,
                    sec_en:    sec_wait_en,
                    auto_ack:  auto_ack_en,
                    wr_hold:   wr_hold,
                    rd_hold:   rd_hold,
                    ext_start: ext_start_en};

  ebus_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  ebus_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_int_n), .cap_en(accept), .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  // Setup delay is loaded straight from the port at acceptance.
  ebus_dcount #(.W(EB_CODE_W)) u_setup_cnt (
    .clk(clk), .rst_n(rst_int_n), .load(accept), .load_val(setup_code),
    .dec(setup_dec), .zero(setup_zero)
  );

  ebus_dcount #(.W(EB_WAIT_W)) u_wait_cnt (
    .clk(clk), .rst_n(rst_int_n), .load(wait_ld), .load_val(wait_val),
    .dec(wait_dec), .zero(wait_zero)
  );

  ebus_dcount #(.W(EB_CODE_W)) u_hold_cnt (
    .clk(clk), .rst_n(rst_int_n), .load(hold_ld), .load_val(hold_val),
    .dec(hold_dec), .zero(hold_zero)
  );

  ebus_addr_gen #(.ADDR_W(ADDR_W), .ADDR_STEP(ADDR_STEP)) u_addr (
    .clk(clk), .rst_n(rst_int_n), .load(accept), .base(base_addr),
    .adv(addr_adv), .addr(addr_out)
  );

  ebus_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n), .start(start), .cfg(cfg_q), .ext_ack(ext_ack),
    .setup_zero(setup_zero), .wait_zero(wait_zero), .hold_zero(hold_zero),
    .accept(accept), .setup_dec(setup_dec), .wait_ld(wait_ld), .wait_val(wait_val),
    .wait_dec(wait_dec), .hold_ld(hold_ld), .hold_val(hold_val), .hold_dec(hold_dec),
    .addr_adv(addr_adv), .ts_out(ts_out), .cs_en(cs_en), .addr_valid(addr_valid),
    .int_ack(int_ack), .done(done)
  );
endmodule

// File: rtl/ebus_cycle_seq_chk.sv
module ebus_cycle_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ts_out,
  input logic cs_en,
  input logic addr_valid,
  input logic int_ack,
  input logic done,
  input logic ext_ack
);
  // R3
  ack_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> cs_en);

  // R4
  beat_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_en && !int_ack && !ext_ack) |=> cs_en);

  // R2
  setup_before_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_en) |-> $past(addr_valid));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid);

  // R9
  strobe_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_out |-> addr_valid);
endmodule

bind ebus_cycle_seq ebus_cycle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ts_out(ts_out), .cs_en(cs_en),
  .addr_valid(addr_valid), .int_ack(int_ack), .done(done), .ext_ack(ext_ack)
);

// File: tb/ebus_cycle_seq_bench.sv
`timescale 1ns/1ps
module ebus_cycle_seq_bench;
  import ebus_seq_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, is_write = 1'b0, sec_wait_en = 1'b0, auto_ack_en = 1'b0;
  logic ext_start_en = 1'b0, ext_ack = 1'b0;
  logic [EB_BEAT_W-1:0] beats_m1 = '0;
  logic [31:0]          base_addr = '0;
  logic [EB_CODE_W-1:0] setup_code = '0, wr_hold = '0, rd_hold = '0;
  logic [EB_WAIT_W-1:0] wait_pri = '0, wait_sec = '0;
  logic ts_out, cs_en, addr_valid, int_ack, done;
  logic [31:0] addr_out;

  always #2.5 clk = ~clk;

  ebus_cycle_seq u_ebus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
    .beats_m1(beats_m1), .base_addr(base_addr), .setup_code(setup_code),
    .wait_pri(wait_pri), .wait_sec(wait_sec), .sec_wait_en(sec_wait_en),
    .auto_ack_en(auto_ack_en), .wr_hold(wr_hold), .rd_hold(rd_hold),
    .ext_start_en(ext_start_en), .ext_ack(ext_ack), .ts_out(ts_out),
    .cs_en(cs_en), .addr_valid(addr_valid), .addr_out(addr_out),
    .int_ack(int_ack), .done(done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  // Configuration of the access under test
  int c_setup, c_ext, c_auto, c_wr, c_wh, c_rh, c_wpri, c_wsec, c_sen, c_bm1, c_L, c_useext;
  int c_base;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp_v);
    end
  endtask

  task automatic run(input bit scr);
    int lenb[16];
    int wb[16];
    int cs_start, cs_end, hh, dn, nb, acc, b, r;
    bit in_cs;
    string t_cs, t_av, t_ia, t_ts, t_dn, t_ad;
    nb = c_bm1 + 1;
    cs_start = c_setup + 1;
    cs_end = cs_start;
    for (int i = 0; i < nb; i++) begin
      wb[i] = (i > 0 && c_sen != 0) ? c_wsec : c_wpri;
      if (c_auto == 0) lenb[i] = c_L + 1;
      else if (c_useext != 0 && c_L < wb[i]) lenb[i] = c_L + 1;
      else lenb[i] = wb[i] + 1;
      cs_end += lenb[i];
    end
    hh = (c_wr != 0) ? c_wh + 1 : c_rh + ((c_auto != 0) ? 0 : 1);
    dn = cs_end + hh;

    @(negedge clk);
    is_write = c_wr[0]; beats_m1 = EB_BEAT_W'(c_bm1); base_addr = 32'(c_base);
    setup_code = EB_CODE_W'(c_setup); wait_pri = EB_WAIT_W'(c_wpri);
    wait_sec = EB_WAIT_W'(c_wsec); sec_wait_en = c_sen[0]; auto_ack_en = c_auto[0];
    wr_hold = EB_CODE_W'(c_wh); rd_hold = EB_CODE_W'(c_rh); ext_start_en = c_ext[0];
    ext_ack = 1'b0; start = 1'b1;

    for (int k = 0; k <= dn + 1; k++) begin
      @(negedge clk);
      cyc = k;
      in_cs = (k >= cs_start) && (k < cs_end);
      b = 0; r = 0; acc = cs_start;
      if (in_cs) begin
        for (int i = 0; i < nb; i++) begin
          if (k >= acc && k < acc + lenb[i]) begin b = i; r = k - acc; end
          acc += lenb[i];
        end
      end
      t_ts = "R9"; t_cs = (k <= cs_start) ? "R2" : "R8";
      t_av = (c_wr != 0) ? "R6" : "R7"; t_dn = "R10"; t_ad = "R12";
      if (c_auto == 0 || c_useext != 0) t_ia = "R4";
      else if (b > 0) t_ia = "R5";
      else t_ia = "R3";
      if (scr) begin t_ts = "R11"; t_cs = "R11"; t_av = "R11"; t_ia = "R11"; t_dn = "R11"; t_ad = "R11"; end
      chk(t_ts, 32'(ts_out), 32'((k == 0) || (c_ext != 0 && k <= c_setup + 1)));
      chk(t_cs, 32'(cs_en), 32'(in_cs));
      chk(t_av, 32'(addr_valid), 32'(k < dn));
      chk(t_ia, 32'(int_ack), 32'(in_cs && c_auto != 0 && r == wb[b]));
      chk(t_dn, 32'(done), 32'(k == dn));
      if (in_cs) chk(t_ad, addr_out, 32'(c_base + b * 4));
      // inputs for the edge that closes cycle k
      if (scr && k == 0) begin
        is_write = ~is_write; beats_m1 = beats_m1 + 1'b1; base_addr = base_addr ^ 32'h00ff_0000;
        setup_code = ~setup_code; wait_pri = wait_pri + 6'd7; wait_sec = wait_sec + 6'd9;
        sec_wait_en = ~sec_wait_en; auto_ack_en = ~auto_ack_en; wr_hold = ~wr_hold;
        rd_hold = ~rd_hold; ext_start_en = ~ext_start_en;
      end
      start = (scr && k < dn) ? 1'b1 : 1'b0;
      ext_ack = (in_cs && (c_auto == 0 || c_useext != 0) && r == c_L) ? 1'b1 : 1'b0;
    end
    start = 1'b0; ext_ack = 1'b0;
  endtask

  task automatic idle_check(input string tag);
    chk(tag, 32'(ts_out), 32'd0);
    chk(tag, 32'(cs_en), 32'd0);
    chk(tag, 32'(addr_valid), 32'd0);
    chk(tag, 32'(int_ack), 32'd0);
    chk(tag, 32'(done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    idle_check("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_check("R1");

    c_L = 0; c_useext = 0; c_base = 32'h0001_0000;
    // Auto-acknowledge sweep over setup, strobe, direction, hold, waits and bursts
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 2; e++)
        for (int w = 0; w < 2; w++)
          for (int h = 0; h < 4; h++)
            for (int wp = 0; wp < 2; wp++)
              for (int se = 0; se < 2; se++)
                for (int bm = 0; bm < 2; bm++) begin
                  c_setup = s; c_ext = e; c_auto = 1; c_wr = w; c_wh = h; c_rh = 3 - h;
                  c_wpri = wp * 2; c_sen = se; c_wsec = 1; c_bm1 = bm * 2;
                  c_base = c_base + 32'h40;
                  run(1'b0);
                end

    // R3: widest wait count, with a secondary count on the later beat
    c_setup = 1; c_ext = 0; c_auto = 1; c_wr = 0; c_wh = 0; c_rh = 2;
    c_wpri = 63; c_wsec = 63; c_sen = 1; c_bm1 = 1; c_useext = 0;
    run(1'b0);

    // R4: no auto-acknowledge, only the external acknowledge ends beats
    for (int s = 0; s < 4; s += 3)
      for (int w = 0; w < 2; w++)
        for (int h = 0; h < 4; h++)
          for (int li = 0; li < 3; li++)
            for (int bm = 0; bm < 2; bm++) begin
              c_setup = s; c_ext = w; c_auto = 0; c_wr = w; c_wh = h; c_rh = h;
              c_wpri = 2; c_wsec = 0; c_sen = 0; c_bm1 = bm * 2;
              c_L = (li == 0) ? 0 : ((li == 1) ? 1 : 4); c_useext = 1;
              c_base = c_base + 32'h100;
              run(1'b0);
            end

    // R4/R5: auto-acknowledge with an external acknowledge earlier, equal or later
    for (int l = 0; l < 7; l++) begin
      c_setup = 0; c_ext = 1; c_auto = 1; c_wr = 1; c_wh = 1; c_rh = 0;
      c_wpri = 5; c_wsec = 3; c_sen = 1; c_bm1 = 2; c_L = l; c_useext = 1;
      run(1'b0);
    end

    // R11: start held high and settings changed during the access
    c_setup = 2; c_ext = 1; c_auto = 1; c_wr = 0; c_wh = 2; c_rh = 1;
    c_wpri = 2; c_wsec = 4; c_sen = 1; c_bm1 = 2; c_L = 0; c_useext = 0;
    c_base = 32'h0800_0000;
    run(1'b1);
    c_wr = 1; c_rh = 0; c_auto = 1; c_ext = 0;
    run(1'b1);

    // R1: reset during an access
    @(negedge clk);
    setup_code = 2'd3; wait_pri = 6'd10; auto_ack_en = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    idle_check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_check("R1");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule